// File: doc/BRIEF.md
# Ripple Adder-Subtractor with Signed Overflow Trap

This block is an integer adder/subtractor that feeds the second operand either from a full-width register value or from a short immediate. The immediate is widened by sign extension. The datapath is a plain chain of one-bit full adders with no carry acceleration. A single mode input selects between sum and difference. Subtraction inverts the second operand and injects a one at the bottom carry.

The result leaves with the final carry and a raw signed-overflow flag. A separate trap request is the overflow flag gated by a signed/unsigned select. Signed operations raise the trap, and unsigned operations leave it low. The overflow flag itself stays visible in both cases. The block is purely combinational, and every output follows its inputs within the same cycle.

Top module: `addsub_trap`

## Requirements
- R1: With sub_i=0 the result sum_o is (a_i + operand) modulo 2^32, and carry_o is bit 32 of the full 33-bit sum, where operand is the second operand selected per R3.
- R2: With sub_i=1 the result sum_o is (a_i - operand) modulo 2^32, formed as a_i + ~operand + 1, and carry_o is bit 32 of that sum, so it is 1 exactly when a_i >= operand unsigned.
- R3: With use_imm_i=1 the second operand is imm_i widened to 32 bits by copying imm_i bit 15 into bits 31..16, for either value of signed_i; with use_imm_i=0 it is b_i.
- R4: When adding, ovf_o is 1 exactly when both operands have the same bit 31 and sum_o bit 31 differs from it.
- R5: When subtracting, ovf_o is 1 exactly when the operands differ in bit 31 and sum_o bit 31 differs from bit 31 of a_i.
- R6: An addition of operands whose bit 31 differs, or a subtraction of operands whose bit 31 matches, never sets ovf_o.
- R7: trap_o is 1 exactly when ovf_o is 1 and signed_i is 1; with signed_i=0 trap_o stays 0.
- R8: ovf_o depends only on the operands, the immediate select and sub_i, and shows the same value for signed_i=0 and signed_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand when the immediate is not selected |
| imm_i | input | 16 | Short immediate, sign-extended when selected |
| use_imm_i | input | 1 | 1 selects the widened immediate as the second operand |
| sub_i | input | 1 | 0 adds, 1 subtracts |
| signed_i | input | 1 | 1 lets overflow raise the trap |
| sum_o | output | 32 | Sum or difference |
| carry_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Signed overflow flag |
| trap_o | output | 1 | Overflow exception request |

## Verification
The hardest case to reach is the overflow of a subtraction, because the relation depends on the operand signs before inversion and not on the adder's inputs. Random operands seldom land on the edges of the signed range. The stimulus therefore drives directed pairs at the range edges: the most positive value minus minus one, the most negative value minus one, and the most negative value with itself. Each pair is replayed with the immediate path and with signed_i low, so the flag and the trap can be seen to separate.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 16;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W,
  parameter int unsigned IMM_W = addsub_pkg::IMM_W
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_eff_o
);
  localparam int unsigned EXT_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] imm_ext;
  logic [WIDTH-1:0] b_sel;

  assign imm_ext[IMM_W-1:0] = imm_i;
  for (genvar g = IMM_W; g < WIDTH; g++) begin : g_ext
    assign imm_ext[g] = imm_i[IMM_W-1];
  end

  assign b_sel = use_imm_i ? imm_ext : b_i;

  // conditional inversion per bit; +1 comes via carry-in
  for (genvar g = 0; g < WIDTH; g++) begin : g_inv
    assign b_eff_o[g] = b_sel[g] ^ sub_i;
  end

  if (EXT_W == 0) begin : g_no_ext
  end
endmodule

// File: rtl/addsub_fa.sv
module addsub_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_top_in_o,
  output logic             c_top_out_o
);
  logic [WIDTH:0] c;

  assign c[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    addsub_fa i_fa (
      .a_i (a_i[g]),
      .b_i (b_i[g]),
      .c_i (c[g]),
      .s_o (sum_o[g]),
      .c_o (c[g+1])
    );
  end

  assign c_top_in_o  = c[WIDTH-1];
  assign c_top_out_o = c[WIDTH];
endmodule

// File: rtl/addsub_trap.sv
module addsub_trap #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W,
  parameter int unsigned IMM_W = addsub_pkg::IMM_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sub_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             trap_o
);
  import addsub_pkg::*;

  addsub_op_e       op;
  logic [WIDTH-1:0] b_eff;
  logic             c_top_in;
  logic             c_top_out;

  assign op = addsub_op_e'(sub_i);

  addsub_operand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) i_operand (
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .sub_i     (op == OP_SUB),
    .b_eff_o   (b_eff)
  );

  addsub_chain #(.WIDTH(WIDTH)) i_chain (
    .a_i         (a_i),
    .b_i         (b_eff),
    .cin_i       (op == OP_SUB),
    .sum_o       (sum_o),
    .c_top_in_o  (c_top_in),
    .c_top_out_o (c_top_out)
  );

  assign carry_o = c_top_out;
  // signed overflow: carries into and out of the sign bit disagree
  assign ovf_o   = c_top_in ^ c_top_out;
  assign trap_o  = ovf_o & signed_i;
endmodule

// File: rtl/addsub_trap_chk.sv
module addsub_trap_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IMM_W = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic             sub_i,
  input logic             signed_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             trap_o
);
  logic [WIDTH-1:0] opnd;
  logic [WIDTH:0]   ref_add;
  logic [WIDTH:0]   ref_sub;
  logic             sa, sb, sr;

  always_comb begin
    opnd    = use_imm_i ? {{(WIDTH-IMM_W){imm_i[IMM_W-1]}}, imm_i} : b_i;
    ref_add = {1'b0, a_i} + {1'b0, opnd};
    ref_sub = {1'b0, a_i} + {1'b0, ~opnd} + {{WIDTH{1'b0}}, 1'b1};
    sa      = a_i[WIDTH-1];
    sb      = opnd[WIDTH-1];
    sr      = sum_o[WIDTH-1];
  end

  always_comb begin
    if (!sub_i) AST_ADD_RESULT: assert ({carry_o, sum_o} == ref_add); // R1
    if (sub_i)  AST_SUB_RESULT: assert ({carry_o, sum_o} == ref_sub); // R2
    if (!sub_i) AST_ADD_OVERFLOW: assert (ovf_o == ((sa == sb) && (sr != sa))); // R4
    if (sub_i)  AST_SUB_OVERFLOW: assert (ovf_o == ((sa != sb) && (sr != sa))); // R5
    if ((!sub_i && sa != sb) || (sub_i && sa == sb))
      AST_NO_OVERFLOW: assert (!ovf_o); // R6
    if (!signed_i) AST_TRAP_MASKED: assert (!trap_o); // R7
    if (signed_i)  AST_TRAP_SIGNED: assert (trap_o == ovf_o); // R7
    if (use_imm_i && !sub_i)
      AST_IMM_SEXT: assert (sum_o == a_i + {{(WIDTH-IMM_W){imm_i[IMM_W-1]}}, imm_i}); // R3
  end
endmodule

bind addsub_trap addsub_trap_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) i_addsub_trap_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .sub_i     (sub_i),
  .signed_i  (signed_i),
  .sum_o     (sum_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .trap_o    (trap_o)
);

// File: tb/test_addsub_trap.sv
module test_addsub_trap;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [15:0] imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic        sub_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] sum_o;
  logic        carry_o, ovf_o, trap_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] sum;
    logic        carry;
    logic        ovf;
    logic        trap;
    string       req;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  addsub_trap i_addsub_trap (
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .sub_i     (sub_i),
    .signed_i  (signed_i),
    .sum_o     (sum_o),
    .carry_o   (carry_o),
    .ovf_o     (ovf_o),
    .trap_o    (trap_o)
  );

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                       input logic ui, input logic sb, input logic sg, input string req);
    exp_t        e;
    logic [31:0] opnd;
    logic [32:0] full;
    @(posedge clk);
    #1;
    a_i = a; b_i = b; imm_i = imm; use_imm_i = ui; sub_i = sb; signed_i = sg;
    opnd = ui ? {{16{imm[15]}}, imm} : b;
    full = sb ? ({1'b0, a} - {1'b0, opnd} + 33'h1_0000_0000) : ({1'b0, a} + {1'b0, opnd});
    e.sum   = full[31:0];
    e.carry = full[32];
    if (!sb) e.ovf = (a[31] == opnd[31]) && (full[31] != a[31]);
    else     e.ovf = (a[31] != opnd[31]) && (full[31] != a[31]);
    e.trap  = e.ovf & sg;
    e.req   = req;
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if ({sum_o, carry_o, ovf_o, trap_o} !== {e.sum, e.carry, e.ovf, e.trap}) begin
        bad++;
        $display("FAIL %s: sum=%h c=%b v=%b t=%b expected sum=%h c=%b v=%b t=%b",
                 e.req, sum_o, carry_o, ovf_o, trap_o, e.sum, e.carry, e.ovf, e.trap);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr_a, lfsr_b;
    repeat (2) @(posedge clk);
    #1;
    total++;
    if ({sum_o, carry_o, ovf_o, trap_o} !== 35'd0) begin
      bad++;
      $display("FAIL R1 reset: sum=%h c=%b v=%b t=%b expected all zero", sum_o, carry_o, ovf_o, trap_o);
    end
    rst_ni = 1'b1;

    drive(32'd7, 32'd6, 16'h0, 0, 0, 1, "R1 small add");
    drive(32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 0, "R1 carry wrap");
    drive(32'd7, 32'd6, 16'h0, 0, 1, 1, "R2 sub no borrow");
    drive(32'd3, 32'd5, 16'h0, 0, 1, 1, "R2 sub borrow");
    drive(32'd9, 32'd9, 16'h0, 0, 1, 0, "R2 sub equal");
    drive(32'd10, 32'h0, 16'hFFFF, 1, 0, 1, "R3 imm minus one");
    drive(32'd10, 32'h0, 16'h8000, 1, 1, 0, "R3 imm unsigned sext");
    drive(32'h7FFF_FFF0, 32'h0, 16'h7FFF, 1, 0, 1, "R3 R4 imm positive ovf");
    drive(32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 1, "R4 pos plus pos");
    drive(32'h8000_0000, 32'h8000_0000, 16'h0, 0, 0, 1, "R4 neg plus neg");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 1, 1, "R5 pos minus neg");
    drive(32'h8000_0000, 32'd1, 16'h0, 0, 1, 1, "R5 neg minus pos");
    drive(32'h8000_0000, 32'h0, 16'h0001, 1, 1, 1, "R5 imm neg minus pos");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 0, 0, 1, "R6 mixed add");
    drive(32'h8000_0000, 32'h8000_0000, 16'h0, 0, 1, 1, "R6 same sign sub");
    drive(32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 0, "R7 R8 unsigned ovf no trap");
    drive(32'h8000_0000, 32'd1, 16'h0, 0, 1, 0, "R7 R8 unsigned sub ovf");
    drive(32'h7FFF_FFF0, 32'h0, 16'h7FFF, 1, 0, 0, "R7 imm unsigned masked");

    lfsr_a = 32'hACE1_2357;
    lfsr_b = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      drive(lfsr_a, lfsr_b, lfsr_b[23:8], lfsr_a[3], lfsr_b[5], lfsr_a[7], "R1 R2 R3 R8 sweep");
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule